// File: doc/BRIEF.md
# Receive Frame Buffer with Skip-to-Next-Frame

This block sits on the receive side between a MAC byte stream and the host. Bytes from the MAC land first in a small staging FIFO that the host never sees. Only complete frames are handed on, one entry per cycle, into a larger host data FIFO. Each entry carries a data byte and a flag that marks the final byte of its frame. The host reads that FIFO from its head. The head entry is always shown on the outputs, and a read strobe advances it.

The host can abandon the rest of the frame it is reading. It writes a control word with the top bit set, and the block then pops entries on its own until it has removed one that carries the end-of-frame flag. The top bit reads back as 1 while this skip is running and returns to 0 by itself once the skip is done. If the host FIFO is empty when the skip starts, the block waits for the next frame to arrive and discards that frame.

When the host FIFO backs up and the staging FIFO runs out of room, the frame being received is lost as a whole. The bytes already staged for that frame are withdrawn, and its remaining bytes are ignored. A saturating counter of lost frames can be read by the host and clears when it is read.

Top module: `rx_frame_buf`

## Requirements
- R1: After reset, the control readback is 0, the lost-frame count is 0, the host FIFO is empty and its level is 0.
- R2: A frame's bytes reach the host FIFO in arrival order, and only the final byte carries the end flag (bit 8 of the head entry, {hostRdLast, hostRdData}). No byte of a frame is visible to the host until the frame's last byte has been received.
- R3: A control write with bit 31 = 1 starts a skip, and bit 31 of the readback is 1 from the next cycle on. A write with bit 31 = 0 has no effect. Readback bits 30..0 are always 0.
- R4: During a skip, the block pops host entries up to and including the first entry flagged as a frame end. It then clears bit 31, and the head becomes the first byte of the following frame.
- R5: A skip requested while the host FIFO is empty stays active until an entry with the end flag has arrived and been popped. That whole next frame is discarded.
- R6: While a skip is active, the host read strobe does not pop anything beyond what the skip itself removes.
- R7: A byte that arrives while the staging FIFO is full causes its frame to be lost. The bytes already staged for that frame are withdrawn, and the rest of the frame up to its last byte is ignored. Earlier frames are kept, and later frames are accepted once there is space.
- R8: The lost-frame count rises by exactly 1 per lost frame. On a read strobe it presents its current value, and it reads 0 on the next cycle.
- R9: The lost-frame count saturates at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| macValid | input | 1 | A received byte is present this cycle |
| macData | input | DATA_W | Received byte |
| macLast | input | 1 | This byte ends its frame |
| hostRdEn | input | 1 | Pop the head of the host FIFO |
| hostRdData | output | DATA_W | Head entry data |
| hostRdLast | output | 1 | Head entry is the last byte of a frame |
| hostEmpty | output | 1 | Host FIFO holds no entry |
| hostLevel | output | $clog2(HOST_DEPTH)+1 | Host FIFO entry count (staging not included) |
| ctrlWrEn | input | 1 | Control register write strobe |
| ctrlWrData | input | 32 | Control write data; bit 31 requests a skip |
| ctrlRdData | output | 32 | Control readback; bit 31 = skip in progress |
| dropRdEn | input | 1 | Read strobe for the lost-frame count (clears it) |
| dropCount | output | CNT_W | Lost-frame count |

## Verification
The bench holds back a frame's last byte to show that a partial frame never leaks into the host FIFO. It skips over a frame while the read strobe is held, which catches a design that clears the busy bit early or lets the strobe pop one entry too many. It also requests a skip on an empty FIFO: a design that clears the bit at once would leave the next frame in place instead of discarding it. An overrun in the middle of a frame, behind a full host FIFO, shows whether truncated bytes are withdrawn, whether the frames before and after survive, and whether the loss is counted once. A second instance with a 2-bit counter shows whether the count saturates or wraps.

// File: rtl/rx_frame_buf_pkg.sv
package rx_frame_buf_pkg;

  // Strobes issued by the control to the datapath each cycle
  typedef struct packed {
    logic stageWr;       // write incoming byte into staging
    logic stageCommit;   // incoming byte closes its frame
    logic stageRollback; // withdraw uncommitted bytes of current frame
    logic xferEn;        // move one committed entry into host FIFO
    logic hostPop;       // remove host FIFO head
  } rfbStrobe_t;

  // Flags the datapath reports back
  typedef struct packed {
    logic stageFull;
    logic stageHasFrame;
    logic hostFull;
    logic hostEmpty;
    logic headLast;
  } rfbStatus_t;

endpackage

// File: rtl/rfb_sync_fifo.sv
module rfb_sync_fifo #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 64
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       push,
  input  logic [WIDTH-1:0]           wData,
  input  logic                       pop,
  output logic [WIDTH-1:0]           rData,
  output logic                       empty,
  output logic                       full,
  output logic [$clog2(DEPTH):0]     level
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_LVL = (AW+1)'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW:0] wPtr, rPtr;

  assign level = wPtr - rPtr;
  assign empty = (level == '0);
  assign full  = (level == FULL_LVL);
  assign rData = mem[rPtr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (push && !full) mem[wPtr[AW-1:0]] <= wData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wPtr <= '0;
      rPtr <= '0;
    end else begin
      if (push && !full) wPtr <= wPtr + 1'b1;
      if (pop && !empty) rPtr <= rPtr + 1'b1;
    end
  end
endmodule

// File: rtl/rfb_datapath.sv
module rfb_datapath
  import rx_frame_buf_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int STAGE_DEPTH = 128,
  parameter int HOST_DEPTH  = 64
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [DATA_W-1:0]            macData,
  input  logic                         macLast,
  input  rfbStrobe_t                   strobe,
  output rfbStatus_t                   status,
  output logic [DATA_W-1:0]            hostData,
  output logic                         hostLast,
  output logic [$clog2(HOST_DEPTH):0]  hostLevel
);
  localparam int SAW = $clog2(STAGE_DEPTH);
  localparam int EW  = DATA_W + 1;
  localparam logic [SAW:0] STAGE_FULL = (SAW+1)'(STAGE_DEPTH);

  // Staging FIFO with a commit pointer at the last frame boundary
  logic [EW-1:0] stageMem [STAGE_DEPTH];
  logic [SAW:0]  sWr, sRd, sCommit;
  logic [SAW:0]  stageLevel;
  logic [EW-1:0] stageHead;

  assign stageLevel = sWr - sRd;
  assign stageHead  = stageMem[sRd[SAW-1:0]];

  always_ff @(posedge clk) begin
    if (strobe.stageWr) stageMem[sWr[SAW-1:0]] <= {macLast, macData};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sWr     <= '0;
      sRd     <= '0;
      sCommit <= '0;
    end else begin
      if (strobe.stageRollback)  sWr <= sCommit;
      else if (strobe.stageWr)   sWr <= sWr + 1'b1;
      if (strobe.stageCommit)    sCommit <= sWr + 1'b1;
      if (strobe.xferEn)         sRd <= sRd + 1'b1;
    end
  end

  // Host-visible FIFO
  logic [EW-1:0] hostHead;
  logic          hEmpty, hFull;

  rfb_sync_fifo #(.WIDTH(EW), .DEPTH(HOST_DEPTH)) u_hostFifo (
    .clk   (clk),
    .rstN  (rstN),
    .push  (strobe.xferEn),
    .wData (stageHead),
    .pop   (strobe.hostPop),
    .rData (hostHead),
    .empty (hEmpty),
    .full  (hFull),
    .level (hostLevel)
  );

  assign hostData = hostHead[DATA_W-1:0];
  assign hostLast = hostHead[DATA_W];

  always_comb begin
    status.stageFull     = (stageLevel == STAGE_FULL);
    status.stageHasFrame = (sRd != sCommit);
    status.hostFull      = hFull;
    status.hostEmpty     = hEmpty;
    status.headLast      = hostHead[DATA_W];
  end
endmodule

// File: rtl/rfb_control.sv
module rfb_control
  import rx_frame_buf_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             macValid,
  input  logic             macLast,
  input  logic             hostRdEn,
  input  logic             ctrlWrEn,
  input  logic             ctrlWrSkip,
  input  logic             dropRdEn,
  input  rfbStatus_t       status,
  output rfbStrobe_t       strobe,
  output logic             skipBusy,
  output logic [CNT_W-1:0] dropCount
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic dropping;
  logic acceptByte;
  logic skipDone;

  assign acceptByte = macValid && !dropping;
  assign skipDone   = skipBusy && !status.hostEmpty && status.headLast;

  always_comb begin
    strobe.stageWr       = acceptByte && !status.stageFull;
    strobe.stageCommit   = acceptByte && !status.stageFull && macLast;
    strobe.stageRollback = acceptByte && status.stageFull;
    strobe.xferEn        = status.stageHasFrame && !status.hostFull;
    strobe.hostPop       = !status.hostEmpty && (skipBusy || hostRdEn);
  end

  // Frame-loss tracking: discard through the lost frame's last byte
  always_ff @(posedge clk) begin
    if (!rstN)                                 dropping <= 1'b0;
    else if (strobe.stageRollback)             dropping <= !macLast;
    else if (dropping && macValid && macLast)  dropping <= 1'b0;
  end

  // Self-clearing skip control
  always_ff @(posedge clk) begin
    if (!rstN)                                  skipBusy <= 1'b0;
    else if (!skipBusy && ctrlWrEn && ctrlWrSkip) skipBusy <= 1'b1;
    else if (skipDone)                          skipBusy <= 1'b0;
  end

  // Saturating, clear-on-read lost-frame counter
  always_ff @(posedge clk) begin
    if (!rstN)                   dropCount <= '0;
    else if (dropRdEn)           dropCount <= strobe.stageRollback ? CNT_W'(1) : '0;
    else if (strobe.stageRollback && dropCount != CNT_MAX)
                                 dropCount <= dropCount + 1'b1;
  end
endmodule

// File: rtl/rx_frame_buf.sv
module rx_frame_buf
  import rx_frame_buf_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int STAGE_DEPTH = 128,
  parameter int HOST_DEPTH  = 64,
  parameter int CNT_W       = 32
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         macValid,
  input  logic [DATA_W-1:0]            macData,
  input  logic                         macLast,
  input  logic                         hostRdEn,
  output logic [DATA_W-1:0]            hostRdData,
  output logic                         hostRdLast,
  output logic                         hostEmpty,
  output logic [$clog2(HOST_DEPTH):0]  hostLevel,
  input  logic                         ctrlWrEn,
  input  logic [31:0]                  ctrlWrData,
  output logic [31:0]                  ctrlRdData,
  input  logic                         dropRdEn,
  output logic [CNT_W-1:0]             dropCount
);
  rfbStrobe_t strobe;
  rfbStatus_t status;
  logic       skipBusy;
  logic       unusedWrBits;

  assign unusedWrBits = ^ctrlWrData[30:0];

  rfb_control #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .macValid   (macValid),
    .macLast    (macLast),
    .hostRdEn   (hostRdEn),
    .ctrlWrEn   (ctrlWrEn),
    .ctrlWrSkip (ctrlWrData[31]),
    .dropRdEn   (dropRdEn),
    .status     (status),
    .strobe     (strobe),
    .skipBusy   (skipBusy),
    .dropCount  (dropCount)
  );

  rfb_datapath #(
    .DATA_W(DATA_W), .STAGE_DEPTH(STAGE_DEPTH), .HOST_DEPTH(HOST_DEPTH)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .macData   (macData),
    .macLast   (macLast),
    .strobe    (strobe),
    .status    (status),
    .hostData  (hostRdData),
    .hostLast  (hostRdLast),
    .hostLevel (hostLevel)
  );

  assign hostEmpty  = status.hostEmpty;
  assign ctrlRdData = {skipBusy, 31'b0};
endmodule

// File: rtl/rx_frame_buf_chk.sv
module rx_frame_buf_chk #(
  parameter int HOST_DEPTH = 64,
  parameter int CNT_W      = 32
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        hostRdLast,
  input logic                        hostEmpty,
  input logic [$clog2(HOST_DEPTH):0] hostLevel,
  input logic                        ctrlWrEn,
  input logic [31:0]                 ctrlWrData,
  input logic [31:0]                 ctrlRdData,
  input logic                        dropRdEn,
  input logic [CNT_W-1:0]            dropCount
);
  // R3
  skip_start_needs_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctrlRdData[31]) |-> $past(ctrlWrEn && ctrlWrData[31]));

  // R3
  reserved_bits_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlRdData[30:0] == 31'b0);

  // R4
  skip_ends_on_frame_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ctrlRdData[31]) |-> $past(!hostEmpty && hostRdLast));

  // R8
  drop_single_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(dropRdEn) |-> (dropCount == $past(dropCount) ||
                          dropCount == $past(dropCount) + 1'b1));

  // R2
  host_level_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostLevel <= ($clog2(HOST_DEPTH)+1)'(HOST_DEPTH));
endmodule

bind rx_frame_buf rx_frame_buf_chk #(.HOST_DEPTH(HOST_DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .hostRdLast (hostRdLast),
  .hostEmpty  (hostEmpty),
  .hostLevel  (hostLevel),
  .ctrlWrEn   (ctrlWrEn),
  .ctrlWrData (ctrlWrData),
  .ctrlRdData (ctrlRdData),
  .dropRdEn   (dropRdEn),
  .dropCount  (dropCount)
);

// File: tb/rx_frame_buf_tb.sv
module rx_frame_buf_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rstN = 1'b0;
  logic        macValid = 1'b0;
  logic [7:0]  macData = '0;
  logic        macLast = 1'b0;
  logic        hostRdEn = 1'b0;
  logic        ctrlWrEn = 1'b0;
  logic [31:0] ctrlWrData = '0;
  logic        dropRdEn = 1'b0;

  logic [7:0]  hostRdData;
  logic        hostRdLast, hostEmpty;
  logic [3:0]  hostLevel;
  logic [31:0] ctrlRdData;
  logic [31:0] dropCount;

  logic [7:0]  satRdData;
  logic        satRdLast, satEmpty;
  logic [2:0]  satLevel;
  logic [31:0] satCtrl;
  logic [1:0]  satDrop;

  rx_frame_buf #(.DATA_W(8), .STAGE_DEPTH(16), .HOST_DEPTH(8), .CNT_W(32)) u_dut (
    .clk(clk), .rstN(rstN), .macValid(macValid), .macData(macData), .macLast(macLast),
    .hostRdEn(hostRdEn), .hostRdData(hostRdData), .hostRdLast(hostRdLast),
    .hostEmpty(hostEmpty), .hostLevel(hostLevel), .ctrlWrEn(ctrlWrEn),
    .ctrlWrData(ctrlWrData), .ctrlRdData(ctrlRdData), .dropRdEn(dropRdEn),
    .dropCount(dropCount)
  );

  rx_frame_buf #(.DATA_W(8), .STAGE_DEPTH(4), .HOST_DEPTH(4), .CNT_W(2)) u_sat (
    .clk(clk), .rstN(rstN), .macValid(macValid), .macData(macData), .macLast(macLast),
    .hostRdEn(hostRdEn), .hostRdData(satRdData), .hostRdLast(satRdLast),
    .hostEmpty(satEmpty), .hostLevel(satLevel), .ctrlWrEn(ctrlWrEn),
    .ctrlWrData(ctrlWrData), .ctrlRdData(satCtrl), .dropRdEn(dropRdEn),
    .dropCount(satDrop)
  );

  int compared = 0;
  int mismatched = 0;
  logic [8:0] expQ [$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: send bytes, push the ones expected at the host into the scoreboard
  task automatic sendBytes(input int len, input int seed, input bit endFrame, input bit keep);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      macValid = 1'b1;
      macData  = 8'(seed + i);
      macLast  = endFrame && (i == len - 1);
      if (keep) expQ.push_back({macLast, macData});
    end
    @(negedge clk);
    macValid = 1'b0;
    macLast  = 1'b0;
  endtask

  // Monitor: compare host head against scoreboard, then pop
  task automatic readCheck(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      logic [8:0] exp;
      @(negedge clk);
      exp = (expQ.size() > 0) ? expQ.pop_front() : 9'h1ff;
      chk({req, " not empty"}, {31'b0, hostEmpty}, 32'd0);
      chk({req, " head"}, {23'b0, hostRdLast, hostRdData}, {23'b0, exp});
      hostRdEn = 1'b1;
      @(negedge clk);
      hostRdEn = 1'b0;
    end
  endtask

  task automatic writeCtrl(input logic [31:0] val);
    @(negedge clk);
    ctrlWrEn   = 1'b1;
    ctrlWrData = val;
    @(negedge clk);
    ctrlWrEn   = 1'b0;
    ctrlWrData = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 ctrl", ctrlRdData, 32'h0);
    chk("R1 drop", dropCount, 32'h0);
    chk("R1 empty", {31'b0, hostEmpty}, 32'd1);
    chk("R1 level", {28'b0, hostLevel}, 32'd0);

    // R2 partial frame stays hidden until its last byte
    sendBytes(3, 8'h10, 1'b0, 1'b1);
    idle(10);
    chk("R2 partial hidden", {31'b0, hostEmpty}, 32'd1);
    sendBytes(2, 8'h13, 1'b1, 1'b1);
    idle(10);
    chk("R2 level", {28'b0, hostLevel}, 32'd5);
    readCheck(5, "R2");

    // R3 write without bit 31 does nothing
    writeCtrl(32'h7fff_ffff);
    chk("R3 no start", ctrlRdData, 32'h0);

    // R4 / R6 skip over frame E, land on frame F
    sendBytes(3, 8'h20, 1'b1, 1'b0);
    sendBytes(2, 8'h30, 1'b1, 1'b1);
    idle(15);
    @(negedge clk);
    ctrlWrEn   = 1'b1;
    ctrlWrData = 32'h8000_0000;
    @(negedge clk);
    ctrlWrEn   = 1'b0;
    ctrlWrData = '0;
    hostRdEn   = 1'b1;
    chk("R3 busy readback", ctrlRdData, 32'h8000_0000);
    @(negedge clk);
    @(negedge clk);
    hostRdEn = 1'b0;
    idle(2);
    chk("R4 busy cleared", ctrlRdData, 32'h0);
    chk("R6 level after skip", {28'b0, hostLevel}, 32'd2);
    readCheck(2, "R4");

    // R5 skip on empty FIFO waits and eats the next frame
    writeCtrl(32'h8000_0000);
    idle(10);
    chk("R5 still busy", ctrlRdData, 32'h8000_0000);
    sendBytes(3, 8'h40, 1'b1, 1'b0);
    idle(15);
    chk("R5 cleared", ctrlRdData, 32'h0);
    chk("R5 frame gone", {31'b0, hostEmpty}, 32'd1);
    sendBytes(2, 8'h50, 1'b1, 1'b1);
    idle(10);
    readCheck(2, "R5");

    // R7 / R8 overrun mid-frame behind a full host FIFO
    sendBytes(8, 8'h60, 1'b1, 1'b1);
    idle(20);
    sendBytes(6, 8'h70, 1'b1, 1'b1);
    sendBytes(12, 8'h80, 1'b1, 1'b0);
    sendBytes(4, 8'h90, 1'b1, 1'b1);
    idle(5);
    chk("R7 host full", {28'b0, hostLevel}, 32'd8);
    chk("R8 one loss", dropCount, 32'd1);
    @(negedge clk);
    dropRdEn = 1'b1;
    chk("R8 read value", dropCount, 32'd1);
    @(negedge clk);
    dropRdEn = 1'b0;
    chk("R8 cleared", dropCount, 32'd0);
    readCheck(18, "R7");
    idle(5);
    chk("R7 drained", {31'b0, hostEmpty}, 32'd1);

    // R9 saturation on the 2-bit instance
    @(negedge clk);
    dropRdEn = 1'b1;
    @(negedge clk);
    dropRdEn = 1'b0;
    chk("R9 cleared", {30'b0, satDrop}, 32'd0);
    for (int f = 0; f < 5; f++) sendBytes(6, 8'ha0 + 8 * f, 1'b1, 1'b0);
    idle(3);
    chk("R9 saturated", {30'b0, satDrop}, 32'd3);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule